// File: doc/BRIEF.md
# Load/Store Translation-Miss Replay Controller

This block sequences one load or store at a time between the execution core, a data cache and a page-walk translation unit. An accepted request is captured into a snapshot register and always tried against the data cache first. A clean cache completion ends the operation with a done pulse. A cache error flagged as a paradox ends it at once with a storage exception. Any other cache error (translation miss, permission or change-bit fault) leads to a translation request. After that request succeeds, the captured snapshot is sent to the cache again.

The block holds the four translation-related special registers: fault address, fault status, process identifier and page-table base. Exceptions load the fault address and fault status registers, and software can read and write all four through a small select/data port. The process identifier and table base are driven straight to the translation unit. A replayed request that fails again raises an exception rather than starting a second lookup. This bounds every operation to at most one translation.

Top module: `ls_replay_ctrl`

## Requirements
- R1: After reset, coreReady is 1; dcValid, mmuValid, coreDone and coreExc are 0; and all four special registers read 0.
- R2: A request accepted while coreReady is high is presented to the cache (dcValid high) on the next cycle with its captured address, data, size and load flag. mmuValid stays low unless the cache reports an error.
- R3: When the cache answers dcDone without dcError, coreDone pulses for exactly one cycle, in the cycle after that answer, and no translation request is made.
- R4: A cache error with dcParadox raises coreExc in the next cycle with no translation request. The fault status then holds bit 28 set, bit 25 equal to the inverse of the load flag (1 for stores) and all other bits 0, and the fault address holds the request address zero-extended.
- R5: A first-try cache error without dcParadox asserts mmuValid in the next cycle, carrying the request address and load flag, and drops firstTry to 0.
- R6: After dcDone without mmuFault, the captured request is presented to the cache again in the next cycle. Its fields are unchanged whatever the core inputs did in the meantime.
- R7: On mmuDone with mmuFault, coreExc pulses in the next cycle, the fault status takes the value of mmuFaultBits and the fault address takes the request address.
- R8: A cache error on the replayed request raises coreExc without a second translation request. The fault status then holds bit 27 set, bit 25 set for stores and all other bits 0.
- R9: dcValid and mmuValid, together with their request fields, stay asserted and unchanged for as long as the matching stall input is high.
- R10: coreValid is ignored while coreReady is low, and every accepted request yields exactly one coreDone or coreExc pulse.
- R11: sprSel selects 0 fault address, 1 fault status, 2 process identifier, 3 table base. A cycle with sprWe high writes sprWdata to the selected register. sprRdata returns the selected register combinationally, and registers 2 and 3 drive mmuProcId and mmuTableBase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreValid | input | 1 | Core presents a request |
| coreIsLoad | input | 1 | 1 load, 0 store |
| coreAddr | input | AW | Effective address |
| coreData | input | DW | Store data |
| coreSize | input | SZW | Access size code |
| coreReady | output | 1 | Block idle, request accepted this cycle if coreValid |
| coreDone | output | 1 | Successful completion pulse |
| coreExc | output | 1 | Storage exception pulse |
| sprWe | input | 1 | Special register write strobe |
| sprSel | input | 2 | Special register select |
| sprWdata | input | SW | Special register write data |
| sprRdata | output | SW | Selected special register value |
| dcValid | output | 1 | Cache request valid |
| dcIsLoad | output | 1 | Cache request load flag |
| dcAddr | output | AW | Cache request address |
| dcData | output | DW | Cache request store data |
| dcSize | output | SZW | Cache request size |
| dcStall | input | 1 | Cache cannot take the request this cycle |
| dcDone | input | 1 | Cache finished the access |
| dcError | input | 1 | Cache access failed |
| dcParadox | input | 1 | Failure is a cache paradox |
| mmuValid | output | 1 | Translation request valid |
| mmuIsLoad | output | 1 | Translation request load flag |
| mmuAddr | output | AW | Address to translate |
| mmuProcId | output | SW | Process identifier register |
| mmuTableBase | output | SW | Page-table base register |
| mmuStall | input | 1 | Translation unit cannot take the request |
| mmuDone | input | 1 | Translation finished |
| mmuFault | input | 1 | Translation failed |
| mmuFaultBits | input | SW | Fault status to record on failure |
| firstTry | output | 1 | 1 until the current request has needed a translation |

## Verification
Every outcome path is swept for both loads and stores and for zero to two stall cycles on each handshake. The paths are a clean cache hit, a paradox fault, a translation fault, a translation followed by a clean replay, and a translation followed by a failing replay. Loads against stores set apart the inverted store bit of the paradox and replay status encodings. The stall counts show that requests hold steady and that no outcome arrives early. The core inputs are scrambled with a second, ignored request while the block is busy. A replay that still carries the first request's fields shows the snapshot capture apart from a pass-through of live inputs.

// File: rtl/ls_replay_pkg.sv
package ls_replay_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DC_ISSUE,
    ST_DC_WAIT,
    ST_MMU_LOOKUP,
    ST_MMU_WAIT
  } lsState_e;

  typedef struct packed {
    logic capture;
    logic faultParadox;
    logic faultMmu;
    logic faultReplay;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    SPR_FADDR = 2'd0,
    SPR_FSTAT = 2'd1,
    SPR_PROC  = 2'd2,
    SPR_PTAB  = 2'd3
  } sprSel_e;

endpackage

// File: rtl/ls_replay_ctl.sv
module ls_replay_ctl
  import ls_replay_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       coreValid,
  output logic       coreReady,
  output logic       coreDone,
  output logic       coreExc,
  output logic       dcValid,
  input  logic       dcStall,
  input  logic       dcDone,
  input  logic       dcError,
  input  logic       dcParadox,
  output logic       mmuValid,
  input  logic       mmuStall,
  input  logic       mmuDone,
  input  logic       mmuFault,
  output logic       stage1En,
  output dpStrobe_t  strobe
);

  lsState_e state, stateNext;
  logic doneNext, excNext, stage1Next;

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    doneNext   = 1'b0;
    excNext    = 1'b0;
    stage1Next = stage1En;
    unique case (state)
      ST_IDLE: begin
        if (coreValid) begin
          strobe.capture = 1'b1;
          stage1Next     = 1'b1;
          stateNext      = ST_DC_ISSUE;
        end
      end
      ST_DC_ISSUE: begin
        if (!dcStall) stateNext = ST_DC_WAIT;
      end
      ST_DC_WAIT: begin
        if (dcError) begin
          if (dcParadox) begin
            strobe.faultParadox = 1'b1;
            excNext             = 1'b1;
            stateNext           = ST_IDLE;
          end else if (stage1En) begin
            stage1Next = 1'b0;
            stateNext  = ST_MMU_LOOKUP;
          end else begin
            strobe.faultReplay = 1'b1;
            excNext            = 1'b1;
            stateNext          = ST_IDLE;
          end
        end else if (dcDone) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      ST_MMU_LOOKUP: begin
        if (!mmuStall) stateNext = ST_MMU_WAIT;
      end
      ST_MMU_WAIT: begin
        if (mmuDone) begin
          if (mmuFault) begin
            strobe.faultMmu = 1'b1;
            excNext         = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            stateNext = ST_DC_ISSUE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stage1En <= 1'b0;
      coreDone <= 1'b0;
      coreExc  <= 1'b0;
    end else begin
      state    <= stateNext;
      stage1En <= stage1Next;
      coreDone <= doneNext;
      coreExc  <= excNext;
    end
  end

  assign coreReady = (state == ST_IDLE);
  assign dcValid   = (state == ST_DC_ISSUE);
  assign mmuValid  = (state == ST_MMU_LOOKUP);

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(coreDone && coreExc));

  // R9
  dc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dcValid && dcStall |=> dcValid);

  // R9
  mmu_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmuValid && mmuStall |=> mmuValid);

  // R5
  lookup_after_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    mmuValid |-> !stage1En);

  // R4
  paradox_exc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DC_WAIT) && dcError && dcParadox |=> coreExc && !mmuValid);

  // R8
  no_second_lookup_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DC_WAIT) && dcError && !stage1En |=> coreExc && !mmuValid);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreDone |=> !coreDone);

endmodule

// File: rtl/ls_replay_dp.sv
module ls_replay_dp
  import ls_replay_pkg::*;
#(
  parameter int AW  = 48,
  parameter int DW  = 64,
  parameter int SZW = 2,
  parameter int SW  = 64
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpStrobe_t      strobe,
  input  logic           coreIsLoad,
  input  logic [AW-1:0]  coreAddr,
  input  logic [DW-1:0]  coreData,
  input  logic [SZW-1:0] coreSize,
  input  logic [SW-1:0]  mmuFaultBits,
  input  logic           sprWe,
  input  logic [1:0]     sprSel,
  input  logic [SW-1:0]  sprWdata,
  output logic           reqIsLoad,
  output logic [AW-1:0]  reqAddr,
  output logic [DW-1:0]  reqData,
  output logic [SZW-1:0] reqSize,
  output logic [SW-1:0]  sprRdata,
  output logic [SW-1:0]  procId,
  output logic [SW-1:0]  tableBase
);

  localparam int STORE_BIT   = SW - 1 - 38;
  localparam int PARADOX_BIT = SW - 1 - 35;
  localparam int REPLAY_BIT  = SW - 1 - 36;
  localparam int PAD_W       = SW - AW;

  logic [SW-1:0] faultAddr, faultStat;
  logic [SW-1:0] plainReg [2];
  logic          anyFault;
  logic [SW-1:0] faultStatNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqIsLoad <= 1'b0;
      reqAddr   <= '0;
      reqData   <= '0;
      reqSize   <= '0;
    end else if (strobe.capture) begin
      reqIsLoad <= coreIsLoad;
      reqAddr   <= coreAddr;
      reqData   <= coreData;
      reqSize   <= coreSize;
    end
  end

  assign anyFault = strobe.faultParadox | strobe.faultMmu | strobe.faultReplay;

  always_comb begin
    faultStatNext = '0;
    if (strobe.faultMmu) begin
      faultStatNext = mmuFaultBits;
    end else if (strobe.faultParadox) begin
      faultStatNext[STORE_BIT]   = !reqIsLoad;
      faultStatNext[PARADOX_BIT] = 1'b1;
    end else if (strobe.faultReplay) begin
      faultStatNext[STORE_BIT]  = !reqIsLoad;
      faultStatNext[REPLAY_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultAddr <= '0;
      faultStat <= '0;
    end else if (anyFault) begin
      faultAddr <= {{PAD_W{1'b0}}, reqAddr};
      faultStat <= faultStatNext;
    end else if (sprWe) begin
      if (sprSel_e'(sprSel) == SPR_FADDR) faultAddr <= sprWdata;
      if (sprSel_e'(sprSel) == SPR_FSTAT) faultStat <= sprWdata;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_plain
    always_ff @(posedge clk) begin
      if (!rstN) begin
        plainReg[g] <= '0;
      end else if (sprWe && (sprSel == 2'(g + 2))) begin
        plainReg[g] <= sprWdata;
      end
    end
  end

  assign procId    = plainReg[0];
  assign tableBase = plainReg[1];

  always_comb begin
    unique case (sprSel_e'(sprSel))
      SPR_FADDR: sprRdata = faultAddr;
      SPR_FSTAT: sprRdata = faultStat;
      SPR_PROC:  sprRdata = plainReg[0];
      default:   sprRdata = plainReg[1];
    endcase
  end

  // R6
  snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(reqAddr) && $stable(reqData)
                        && $stable(reqSize) && $stable(reqIsLoad));

  // R4
  paradox_stat_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.faultParadox |=> faultStat[PARADOX_BIT] && !faultStat[REPLAY_BIT]);

  // R10
  one_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.faultParadox, strobe.faultMmu, strobe.faultReplay, strobe.capture}) <= 1);

endmodule

// File: rtl/ls_replay_ctrl.sv
module ls_replay_ctrl
  import ls_replay_pkg::*;
#(
  parameter int AW  = 48,
  parameter int DW  = 64,
  parameter int SZW = 2,
  parameter int SW  = 64
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           coreValid,
  input  logic           coreIsLoad,
  input  logic [AW-1:0]  coreAddr,
  input  logic [DW-1:0]  coreData,
  input  logic [SZW-1:0] coreSize,
  output logic           coreReady,
  output logic           coreDone,
  output logic           coreExc,
  input  logic           sprWe,
  input  logic [1:0]     sprSel,
  input  logic [SW-1:0]  sprWdata,
  output logic [SW-1:0]  sprRdata,
  output logic           dcValid,
  output logic           dcIsLoad,
  output logic [AW-1:0]  dcAddr,
  output logic [DW-1:0]  dcData,
  output logic [SZW-1:0] dcSize,
  input  logic           dcStall,
  input  logic           dcDone,
  input  logic           dcError,
  input  logic           dcParadox,
  output logic           mmuValid,
  output logic           mmuIsLoad,
  output logic [AW-1:0]  mmuAddr,
  output logic [SW-1:0]  mmuProcId,
  output logic [SW-1:0]  mmuTableBase,
  input  logic           mmuStall,
  input  logic           mmuDone,
  input  logic           mmuFault,
  input  logic [SW-1:0]  mmuFaultBits,
  output logic           firstTry
);

  dpStrobe_t      strobe;
  logic           reqIsLoad;
  logic [AW-1:0]  reqAddr;

  ls_replay_ctl i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .coreValid (coreValid),
    .coreReady (coreReady),
    .coreDone  (coreDone),
    .coreExc   (coreExc),
    .dcValid   (dcValid),
    .dcStall   (dcStall),
    .dcDone    (dcDone),
    .dcError   (dcError),
    .dcParadox (dcParadox),
    .mmuValid  (mmuValid),
    .mmuStall  (mmuStall),
    .mmuDone   (mmuDone),
    .mmuFault  (mmuFault),
    .stage1En  (firstTry),
    .strobe    (strobe)
  );

  ls_replay_dp #(.AW(AW), .DW(DW), .SZW(SZW), .SW(SW)) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .coreIsLoad   (coreIsLoad),
    .coreAddr     (coreAddr),
    .coreData     (coreData),
    .coreSize     (coreSize),
    .mmuFaultBits (mmuFaultBits),
    .sprWe        (sprWe),
    .sprSel       (sprSel),
    .sprWdata     (sprWdata),
    .reqIsLoad    (reqIsLoad),
    .reqAddr      (reqAddr),
    .reqData      (dcData),
    .reqSize      (dcSize),
    .sprRdata     (sprRdata),
    .procId       (mmuProcId),
    .tableBase    (mmuTableBase)
  );

  assign dcIsLoad  = reqIsLoad;
  assign dcAddr    = reqAddr;
  assign mmuIsLoad = reqIsLoad;
  assign mmuAddr   = reqAddr;

  // R9
  dc_fields_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dcValid && dcStall |=> $stable(dcAddr) && $stable(dcData) && $stable(dcIsLoad));

  // R2
  cache_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReady && coreValid |=> dcValid && !mmuValid);

endmodule

// File: tb/test_ls_replay_ctrl.sv
`timescale 1ns/1ps
module test_ls_replay_ctrl;

  localparam int AW = 48, DW = 64, SZW = 2, SW = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic coreValid = 0, coreIsLoad = 0;
  logic [AW-1:0] coreAddr = '0;
  logic [DW-1:0] coreData = '0;
  logic [SZW-1:0] coreSize = '0;
  logic coreReady, coreDone, coreExc;
  logic sprWe = 0;
  logic [1:0] sprSel = '0;
  logic [SW-1:0] sprWdata = '0, sprRdata;
  logic dcValid, dcIsLoad;
  logic [AW-1:0] dcAddr;
  logic [DW-1:0] dcData;
  logic [SZW-1:0] dcSize;
  logic dcStall = 0, dcDone = 0, dcError = 0, dcParadox = 0;
  logic mmuValid, mmuIsLoad;
  logic [AW-1:0] mmuAddr;
  logic [SW-1:0] mmuProcId, mmuTableBase;
  logic mmuStall = 0, mmuDone = 0, mmuFault = 0;
  logic [SW-1:0] mmuFaultBits = '0;
  logic firstTry;

  int testCnt = 0, failCnt = 0, pulseCnt = 0;

  always #2.5 clk = ~clk;

  ls_replay_ctrl #(.AW(AW), .DW(DW), .SZW(SZW), .SW(SW)) i_ls_replay_ctrl (.*);

  always @(negedge clk) if (rstN) pulseCnt += int'(coreDone) + int'(coreExc);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic readSpr(input logic [1:0] sel, output logic [SW-1:0] val);
    sprSel = sel;
    #0.5;
    val = sprRdata;
  endtask

  // Called at a negedge where dcValid must be high; returns at the negedge in the wait state.
  task automatic cachePhase(input int stallN, input logic ld, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input logic [SZW-1:0] s, input string req);
    chk(dcValid === 1'b1, req, 64'(dcValid), 64'd1);
    chk(dcAddr === a && dcData === d && dcSize === s && dcIsLoad === ld, req, 64'(dcAddr), 64'(a));
    chk(mmuValid === 1'b0, "R2", 64'(mmuValid), 64'd0);
    coreValid = 1'b1; coreAddr = ~a; coreData = ~d; coreIsLoad = ~ld; coreSize = ~s;
    dcStall = (stallN > 0);
    for (int k = 0; k < stallN; k++) begin
      @(negedge clk);
      coreValid = 1'b0;
      chk(dcValid === 1'b1 && dcAddr === a && dcData === d, "R9", 64'(dcAddr), 64'(a));
      dcStall = (k < stallN - 1);
    end
    @(negedge clk);
    coreValid = 1'b0;
    chk(dcValid === 1'b0 && mmuValid === 1'b0, "R2", 64'({dcValid, mmuValid}), 64'd0);
  endtask

  task automatic runOp(input int op, input logic ld, input int sc, input int stallN);
    logic [AW-1:0] a = AW'(48'h0000_1000_0000 + 48'(op) * 48'h1238);
    logic [DW-1:0] d = 64'hA5C3_0000_0000_0000 ^ 64'(op * 977);
    logic [SZW-1:0] s = SZW'(op);
    logic [SW-1:0] fbits = 64'h0000_0000_4000_0000 | 64'(op);
    logic [SW-1:0] v, expStat;
    int p0;
    bit exc = 1'b0;
    p0 = pulseCnt;
    coreValid = 1'b1; coreAddr = a; coreData = d; coreIsLoad = ld; coreSize = s;
    chk(coreReady === 1'b1, "R10", 64'(coreReady), 64'd1);
    @(negedge clk);
    chk(coreReady === 1'b0 && firstTry === 1'b1, "R2", 64'({coreReady, firstTry}), 64'd1);
    cachePhase(stallN, ld, a, d, s, "R2");
    expStat = '0;
    if (sc == 0) begin
      dcDone = 1'b1;
      @(negedge clk); dcDone = 1'b0;
      chk(coreDone === 1'b1 && coreExc === 1'b0 && mmuValid === 1'b0, "R3",
          64'({coreDone, coreExc, mmuValid}), 64'b100);
    end else if (sc == 1) begin
      dcError = 1'b1; dcParadox = 1'b1;
      @(negedge clk); dcError = 1'b0; dcParadox = 1'b0;
      chk(coreExc === 1'b1 && coreDone === 1'b0 && mmuValid === 1'b0, "R4",
          64'({coreDone, coreExc, mmuValid}), 64'b010);
      expStat = (64'(!ld) << 25) | (64'd1 << 28);
      exc = 1'b1;
    end else begin
      dcError = 1'b1;
      @(negedge clk); dcError = 1'b0;
      chk(mmuValid === 1'b1 && mmuAddr === a && mmuIsLoad === ld, "R5", 64'(mmuAddr), 64'(a));
      chk(firstTry === 1'b0 && coreExc === 1'b0, "R5", 64'({firstTry, coreExc}), 64'd0);
      mmuStall = (stallN > 0);
      for (int k = 0; k < stallN; k++) begin
        @(negedge clk);
        chk(mmuValid === 1'b1 && mmuAddr === a, "R9", 64'(mmuValid), 64'd1);
        mmuStall = (k < stallN - 1);
      end
      @(negedge clk);
      chk(mmuValid === 1'b0, "R5", 64'(mmuValid), 64'd0);
      mmuDone = 1'b1; mmuFault = (sc == 2); mmuFaultBits = fbits;
      @(negedge clk); mmuDone = 1'b0; mmuFault = 1'b0; mmuFaultBits = '0;
      if (sc == 2) begin
        chk(coreExc === 1'b1 && dcValid === 1'b0, "R7", 64'({coreExc, dcValid}), 64'b10);
        expStat = fbits;
        exc = 1'b1;
      end else begin
        cachePhase(stallN, ld, a, d, s, "R6");
        if (sc == 3) begin
          dcDone = 1'b1;
          @(negedge clk); dcDone = 1'b0;
          chk(coreDone === 1'b1 && coreExc === 1'b0, "R6", 64'({coreDone, coreExc}), 64'b10);
        end else begin
          dcError = 1'b1;
          @(negedge clk); dcError = 1'b0;
          chk(coreExc === 1'b1 && mmuValid === 1'b0 && coreDone === 1'b0, "R8",
              64'({coreExc, mmuValid}), 64'b10);
          expStat = (64'(!ld) << 25) | (64'd1 << 27);
          exc = 1'b1;
        end
      end
    end
    chk(coreReady === 1'b1, "R10", 64'(coreReady), 64'd1);
    @(negedge clk);
    chk(pulseCnt == p0 + 1 && !coreDone && !coreExc, "R10", 64'(pulseCnt - p0), 64'd1);
    if (exc) begin
      readSpr(2'd0, v);
      chk(v === {16'h0, a}, sc == 1 ? "R4" : (sc == 2 ? "R7" : "R8"), v, {16'h0, a});
      readSpr(2'd1, v);
      chk(v === expStat, sc == 1 ? "R4" : (sc == 2 ? "R7" : "R8"), v, expStat);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired");
    testCnt++; failCnt++;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [SW-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(coreReady === 1'b1 && dcValid === 1'b0 && mmuValid === 1'b0, "R1",
        64'({coreReady, dcValid, mmuValid}), 64'b100);
    chk(coreDone === 1'b0 && coreExc === 1'b0, "R1", 64'({coreDone, coreExc}), 64'd0);
    for (int i = 0; i < 4; i++) begin
      readSpr(2'(i), v);
      chk(v === '0, "R1", v, 64'd0);
    end
    // R11 special register access
    for (int i = 0; i < 4; i++) begin
      sprWe = 1'b1; sprSel = 2'(i); sprWdata = 64'h1111_0000_0000_0000 * 64'(i + 1) + 64'(i);
      @(negedge clk);
      sprWe = 1'b0;
    end
    for (int i = 0; i < 4; i++) begin
      readSpr(2'(i), v);
      chk(v === 64'h1111_0000_0000_0000 * 64'(i + 1) + 64'(i), "R11", v,
          64'h1111_0000_0000_0000 * 64'(i + 1) + 64'(i));
    end
    chk(mmuProcId === 64'h3333_0000_0000_0002, "R11", mmuProcId, 64'h3333_0000_0000_0002);
    chk(mmuTableBase === 64'h4444_0000_0000_0003, "R11", mmuTableBase, 64'h4444_0000_0000_0003);
    // sweep all outcome paths
    begin
      int op = 0;
      for (int ld = 0; ld < 2; ld++)
        for (int sc = 0; sc < 5; sc++)
          for (int st = 0; st < 3; st++) begin
            runOp(op, 1'(ld), sc, st);
            op++;
          end
    end
    readSpr(2'd2, v);
    chk(v === 64'h3333_0000_0000_0002, "R11", v, 64'h3333_0000_0000_0002);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule